// File: doc/BRIEF.md
# 8x8 Two-Pass Inverse Transform with Pixel Reconstruction

The block takes one 8x8 block of signed 16-bit transform coefficients, one row of eight lanes per accepted cycle. Each row is prescaled, and a lane-wise butterfly network runs over the eight rows. The result is transposed, a rounding bias goes into the first row, and the same butterfly network runs a second time. The second-pass values are shifted down and packed into eight rows of 8-bit pixels. The rows leave in order with a strobe, and a done pulse closes the block.

In put mode the pixels are the clamped transform result. In add mode each result is first added to a predictor byte, and the sum is then clamped. The predictor row for output row r is taken with coefficient row r. The mode is sampled with row 0 and holds for the whole block. A single butterfly unit is shared by both passes. A block therefore takes 8 load cycles, 8 cycles per pass and 8 emit cycles.

Top module: `idct8x8_recon`

## Requirements
- R1: Lane l of a coefficient row r goes through two steps. First, shift left by 4 in 16 bits, with wrap. Then take sat16(((v*s + 16384) >>> 15) + 0), where s is the scale for that row and lane. The scale sets are A=(16384,22725,21407,19266,16384,19266,21407,22725), B=(22725,31521,29692,26722,22725,26722,29692,31521), C=(21407,29692,27969,25172,21407,25172,27969,29692) and D=(19266,26722,25172,22654,19266,22654,25172,26722). Rows 0..7 use A,B,C,D,A,D,C,B.
- R2: The first pass applies the saturating butterfly lane-wise across the eight prescaled rows, and the 8x8 result is then transposed. The butterfly uses the constants 23170, 13573, 6518 and 21895, the rounded Q15 multiply-add, and saturating add and subtract.
- R3: After the transpose, only row 0 gets a bias: 32 on even lanes and 31 on odd lanes, added with 16-bit saturation.
- R4: The second pass uses the same butterfly, lane-wise. Each result is then arithmetically shifted right by 6.
- R5: Put mode (add_mode_i=0 at row 0) clamps each shifted result to 0..255.
- R6: Add mode (add_mode_i=1 at row 0) zero-extends the predictor byte and adds it to the shifted result with 16-bit saturation, then clamps the sum to 0..255.
- R7: Output rows come out in order 0..7, with row_valid_o high and row_idx_o equal to the row number. Row k is visible 17+k cycles after the edge that accepts coefficient row 7.
- R8: done_o is a one-cycle pulse in the cycle after row 7 is presented. in_ready_o is low from the acceptance of row 7 until the done cycle, and it is high in the done cycle. Rows offered while in_ready_o is low are ignored.
- R9: add_mode_i is used only with row 0. Its value on rows 1..7 and while the block is busy has no effect on the pixels.
- R10: During reset, in_ready_o=1, row_valid_o=0 and done_o=0.
- R11: Pixel lane l sits at bits [8l+7:8l], coefficient lane l at [16l+15:16l] and predictor lane l at [8l+7:8l].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Coefficient row offered |
| in_ready_o | output | 1 | Block accepts a row this cycle |
| add_mode_i | input | 1 | 1: add to predictor, 0: put; sampled with row 0 |
| coef_row_i | input | 128 | Eight signed 16-bit coefficients |
| pred_row_i | input | 64 | Eight predictor bytes for the same row index |
| row_valid_o | output | 1 | Output pixel row valid |
| row_idx_o | output | 3 | Index of the presented row |
| pix_row_o | output | 64 | Eight reconstructed pixels |
| done_o | output | 1 | Block finished pulse |

## Verification
Two events can fall in one cycle. The done pulse of one block can coincide with acceptance of row 0 of the next, because in_ready_o rises together with done_o. The bench keeps in_valid_i high with junk data and a random mode while the block is busy, so the next block enters on the very first ready cycle. The judgement is twofold. The pixels of both blocks must match the behavioural model, and the junk must have changed nothing. done_o must follow row 7 immediately and coincide with in_ready_o.

// File: rtl/idct_pkg.sv
package idct_pkg;
  localparam int unsigned N    = 8;
  localparam int unsigned CW   = 16;
  localparam int unsigned PW   = 8;
  localparam int unsigned IDXW = $clog2(N);

  localparam int C4 = 23170;
  localparam int K0 = 13573;
  localparam int K1 = 6518;
  localparam int K2 = 21895;

  typedef logic signed [CW-1:0] coef_t;
  typedef coef_t [N-1:0] vec_t;

  typedef enum logic [2:0] {ST_LOAD, ST_PASS1, ST_PASS2, ST_EMIT, ST_DONE} st_e;

  function automatic coef_t sat16(input int x);
    if (x > 32767) return 16'sh7fff;
    else if (x < -32768) return 16'sh8000;
    else return coef_t'(x);
  endfunction

  // rounded Q15 multiply plus addend, saturated
  function automatic coef_t mr(input coef_t a, input coef_t b, input coef_t c);
    int p;
    p = int'(a) * int'(b);
    p = (p + 16384) >>> 15;
    return sat16(p + int'(c));
  endfunction

  function automatic coef_t sadd(input coef_t a, input coef_t b);
    return sat16(int'(a) + int'(b));
  endfunction

  function automatic coef_t ssub(input coef_t a, input coef_t b);
    return sat16(int'(a) - int'(b));
  endfunction

  function automatic logic [PW-1:0] clamp_u8(input coef_t v);
    if (v < 0) return '0;
    else if (v > 255) return '1;
    else return v[PW-1:0];
  endfunction

  // mirror index 0..7 -> 0,1,2,3,0,3,2,1
  function automatic int unsigned fold8(input int unsigned i);
    if (i < 4) return i;
    else if (i == 4) return 0;
    else return 8 - i;
  endfunction

  function automatic coef_t scale_val(input int unsigned set, input int unsigned lane);
    int unsigned k;
    int v;
    k = fold8(lane);
    v = 0;
    case (set)
      0: case (k) 0: v = 16384; 1: v = 22725; 2: v = 21407; default: v = 19266; endcase
      1: case (k) 0: v = 22725; 1: v = 31521; 2: v = 29692; default: v = 26722; endcase
      2: case (k) 0: v = 21407; 1: v = 29692; 2: v = 27969; default: v = 25172; endcase
      default: case (k) 0: v = 19266; 1: v = 26722; 2: v = 25172; default: v = 22654; endcase
    endcase
    return coef_t'(v);
  endfunction
endpackage

// File: rtl/idct_prescale.sv
module idct_prescale
  import idct_pkg::*;
#(
  parameter int unsigned SHL = 4
) (
  input  vec_t            row_i,
  input  logic [IDXW-1:0] row_idx_i,
  output vec_t            row_o
);
  int unsigned set_sel;
  assign set_sel = fold8(32'(row_idx_i));

  for (genvar l = 0; l < N; l++) begin : g_lane
    coef_t sh;
    assign sh = row_i[l] << SHL;  // wraps in 16 bits
    assign row_o[l] = mr(sh, scale_val(set_sel, l), '0);
  end
endmodule

// File: rtl/idct_butterfly.sv
module idct_butterfly
  import idct_pkg::*;
(
  input  vec_t x_i,
  output vec_t y_o
);
  always_comb begin
    coef_t t0, t1, t2, t3, t4, t5, t6, t7, t8;
    coef_t u0, u1, u2, u3, u4, u5, u8;
    // stage 1
    t1 = mr(coef_t'(K1), x_i[7], x_i[1]);
    t8 = mr(coef_t'(K1), x_i[1], ssub('0, x_i[7]));
    t7 = mr(coef_t'(K2), x_i[5], x_i[3]);
    t3 = mr(coef_t'(-K2), x_i[3], x_i[5]);
    // stage 2
    t5 = sadd(x_i[0], x_i[4]);
    t0 = ssub(x_i[0], x_i[4]);
    t2 = mr(coef_t'(K0), x_i[6], x_i[2]);
    t4 = mr(coef_t'(K0), x_i[2], ssub('0, x_i[6]));
    t6 = sadd(t8, t3);
    u3 = ssub(t8, t3);
    u8 = ssub(t1, t7);
    u1 = sadd(t1, t7);
    // stage 3
    u0 = sadd(t5, t2);
    u2 = ssub(t5, t2);
    u5 = sadd(t0, t4);
    t0 = ssub(t0, t4);
    u4 = ssub(u8, u3);
    u3 = sadd(u8, u3);
    // stage 4
    y_o[0] = sadd(u0, u1);
    y_o[7] = ssub(u0, u1);
    y_o[1] = mr(coef_t'(C4), u3, u5);
    y_o[6] = mr(coef_t'(-C4), u3, u5);
    y_o[2] = mr(coef_t'(C4), u4, t0);
    y_o[5] = mr(coef_t'(-C4), u4, t0);
    y_o[3] = sadd(u2, t6);
    y_o[4] = ssub(u2, t6);
  end
endmodule

// File: rtl/idct_out_pack.sv
module idct_out_pack
  import idct_pkg::*;
#(
  parameter int unsigned SHR = 6
) (
  input  vec_t              res_i,
  input  logic [N*PW-1:0]   pred_i,
  input  logic              add_i,
  output logic [N*PW-1:0]   pix_o
);
  for (genvar l = 0; l < N; l++) begin : g_lane
    coef_t sh, sum;
    assign sh  = $signed(res_i[l]) >>> SHR;
    assign sum = sadd(sh, coef_t'({{(CW-PW){1'b0}}, pred_i[l*PW +: PW]}));
    assign pix_o[l*PW +: PW] = clamp_u8(add_i ? sum : sh);
  end
endmodule

// File: rtl/idct8x8_recon.sv
module idct8x8_recon
  import idct_pkg::*;
#(
  parameter int unsigned IN_SHL    = 4,
  parameter int unsigned OUT_SHR   = 6,
  parameter int          BIAS_EVEN = 32,
  parameter int          BIAS_ODD  = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              add_mode_i,
  input  logic [N*CW-1:0]   coef_row_i,
  input  logic [N*PW-1:0]   pred_row_i,
  output logic              row_valid_o,
  output logic [IDXW-1:0]   row_idx_o,
  output logic [N*PW-1:0]   pix_row_o,
  output logic              done_o
);
  localparam logic [IDXW-1:0] LAST = IDXW'(N - 1);

  st_e             state_q;
  logic [IDXW-1:0] cnt_q;
  vec_t            buf_a_q [N];
  vec_t            buf_b_q [N];
  logic [N*PW-1:0] pred_q  [N];
  logic            add_q;

  vec_t            in_row, pre_row, bf_x, bf_y, biased;
  logic [N*PW-1:0] pack_pix;

  logic            row_valid_q, done_q;
  logic [IDXW-1:0] row_idx_q;
  logic [N*PW-1:0] pix_q;

  for (genvar l = 0; l < N; l++) begin : g_unpack
    assign in_row[l] = coef_row_i[l*CW +: CW];
    assign biased[l] = sadd(bf_y[l], coef_t'((l % 2) ? BIAS_ODD : BIAS_EVEN));
  end

  idct_prescale #(.SHL(IN_SHL)) u_pre (
    .row_i     (in_row),
    .row_idx_i (cnt_q),
    .row_o     (pre_row)
  );

  // shared butterfly: column cnt_q of A in pass 1, of B in pass 2
  always_comb begin
    for (int k = 0; k < N; k++) begin
      bf_x[k] = (state_q == ST_PASS2) ? buf_b_q[k][cnt_q] : buf_a_q[k][cnt_q];
    end
  end

  idct_butterfly u_bf (
    .x_i (bf_x),
    .y_o (bf_y)
  );

  idct_out_pack #(.SHR(OUT_SHR)) u_pack (
    .res_i  (buf_a_q[cnt_q]),
    .pred_i (pred_q[cnt_q]),
    .add_i  (add_q),
    .pix_o  (pack_pix)
  );

  // data storage, no reset
  always_ff @(posedge clk_i) begin
    case (state_q)
      ST_LOAD: if (in_valid_i) begin
        buf_a_q[cnt_q] <= pre_row;
        pred_q[cnt_q]  <= pred_row_i;
        if (cnt_q == '0) add_q <= add_mode_i;
      end
      ST_PASS1: buf_b_q[cnt_q] <= (cnt_q == '0) ? biased : bf_y;  // transposed write
      ST_PASS2: for (int k = 0; k < N; k++) buf_a_q[k][cnt_q] <= bf_y[k];
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_LOAD;
      cnt_q       <= '0;
      row_valid_q <= 1'b0;
      row_idx_q   <= '0;
      pix_q       <= '0;
      done_q      <= 1'b0;
    end else begin
      row_valid_q <= 1'b0;
      done_q      <= 1'b0;
      case (state_q)
        ST_LOAD: if (in_valid_i) begin
          cnt_q <= cnt_q + IDXW'(1);
          if (cnt_q == LAST) state_q <= ST_PASS1;
        end
        ST_PASS1: begin
          cnt_q <= cnt_q + IDXW'(1);
          if (cnt_q == LAST) state_q <= ST_PASS2;
        end
        ST_PASS2: begin
          cnt_q <= cnt_q + IDXW'(1);
          if (cnt_q == LAST) state_q <= ST_EMIT;
        end
        ST_EMIT: begin
          row_valid_q <= 1'b1;
          row_idx_q   <= cnt_q;
          pix_q       <= pack_pix;
          cnt_q       <= cnt_q + IDXW'(1);
          if (cnt_q == LAST) state_q <= ST_DONE;
        end
        default: begin
          done_q  <= 1'b1;
          state_q <= ST_LOAD;
        end
      endcase
    end
  end

  assign in_ready_o  = (state_q == ST_LOAD);
  assign row_valid_o = row_valid_q;
  assign row_idx_o   = row_idx_q;
  assign pix_row_o   = pix_q;
  assign done_o      = done_q;
endmodule

// File: rtl/idct8x8_recon_chk.sv
module idct8x8_recon_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_ready_o,
  input logic       row_valid_o,
  input logic [2:0] row_idx_o,
  input logic       done_o
);
  // R7
  row_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_valid_o && row_idx_o != 3'd0) |-> ($past(row_valid_o) && $past(row_idx_o) == row_idx_o - 3'd1));

  // R7
  row_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_valid_o && row_idx_o == 3'd0) |-> !$past(row_valid_o));

  // R8
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(row_valid_o) && $past(row_idx_o) == 3'd7 && !row_valid_o));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_valid_o |-> !in_ready_o);

  // R8
  done_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> in_ready_o);
endmodule

bind idct8x8_recon idct8x8_recon_chk u_chk (.*);

// File: tb/idct8x8_recon_tb_top.sv
module idct8x8_recon_tb_top;
  localparam int NBLK = 48;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic        add_mode_i = 1'b0;
  logic [127:0] coef_row_i = '0;
  logic [63:0] pred_row_i = '0;
  logic        row_valid_o;
  logic [2:0]  row_idx_o;
  logic [63:0] pix_row_o;
  logic        done_o;

  always #2 clk_i = ~clk_i;

  idct8x8_recon dut_i (.*);

  int n_chk = 0, n_fail = 0, cyc = 0, acc_cyc = 0;
  bit finished = 0;
  logic [63:0] exp_q[$];
  bit          mode_q[$];
  int blk_c[8][8], blk_p[8][8], mat[8][8], tmp[8][8];
  int scl[4][8] = '{'{16384,22725,21407,19266,16384,19266,21407,22725},
                    '{22725,31521,29692,26722,22725,26722,29692,31521},
                    '{21407,29692,27969,25172,21407,25172,27969,29692},
                    '{19266,26722,25172,22654,19266,22654,25172,26722}};
  int rset[8] = '{0,1,2,3,0,3,2,1};

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic int sat(int x);
    return (x > 32767) ? 32767 : ((x < -32768) ? -32768 : x);
  endfunction
  function automatic int wrap(int x);
    return ((x & 32'hffff) ^ 32'h8000) - 32'h8000;
  endfunction
  function automatic int mul(int a, int b, int c);
    return sat(((a * b + 16384) >>> 15) + c);
  endfunction

  // lane-wise butterfly across the 8 rows of mat
  task automatic half_pass();
    for (int l = 0; l < 8; l++) begin
      int x[8];
      int a1, a8, a7, a3, a5, a0, a2, a4, a6, b3, b8, b1, b7, b2, b5, b0, b4, b3b;
      for (int k = 0; k < 8; k++) x[k] = mat[k][l];
      a1 = mul(6518, x[7], x[1]);   a8 = mul(6518, x[1], sat(-x[7]));
      a7 = mul(21895, x[5], x[3]);  a3 = mul(-21895, x[3], x[5]);
      a5 = sat(x[0] + x[4]);        a0 = sat(x[0] - x[4]);
      a2 = mul(13573, x[6], x[2]);  a4 = mul(13573, x[2], sat(-x[6]));
      a6 = sat(a8 + a3); b3 = sat(a8 - a3); b8 = sat(a1 - a7); b1 = sat(a1 + a7);
      b7 = sat(a5 + a2); b2 = sat(a5 - a2); b5 = sat(a0 + a4); b0 = sat(a0 - a4);
      b4 = sat(b8 - b3); b3b = sat(b8 + b3);
      mat[0][l] = sat(b7 + b1);             mat[7][l] = sat(b7 - b1);
      mat[1][l] = mul(23170, b3b, b5);      mat[6][l] = mul(-23170, b3b, b5);
      mat[2][l] = mul(23170, b4, b0);       mat[5][l] = mul(-23170, b4, b0);
      mat[3][l] = sat(b2 + a6);             mat[4][l] = sat(b2 - a6);
    end
  endtask

  task automatic model(bit addm);
    for (int r = 0; r < 8; r++)
      for (int l = 0; l < 8; l++)
        mat[r][l] = mul(wrap(blk_c[r][l] << 4), scl[rset[r]][l], 0);  // R1
    half_pass();                                                     // R2
    for (int r = 0; r < 8; r++) for (int l = 0; l < 8; l++) tmp[l][r] = mat[r][l];
    mat = tmp;
    for (int l = 0; l < 8; l++) mat[0][l] = sat(mat[0][l] + ((l % 2) ? 31 : 32));  // R3
    half_pass();
    for (int r = 0; r < 8; r++) begin
      logic [63:0] row;
      for (int l = 0; l < 8; l++) begin
        int v;
        v = mat[r][l] >>> 6;                  // R4
        if (addm) v = sat(v + blk_p[r][l]);  // R6
        v = (v < 0) ? 0 : ((v > 255) ? 255 : v);  // R5
        row[l*8 +: 8] = v[7:0];
      end
      exp_q.push_back(row);
      mode_q.push_back(addm);
    end
  endtask

  task automatic gen_block(int b, output bit addm);
    int pat;
    pat = b % 8;
    addm = ((b >> 3) ^ b) & 1;
    for (int r = 0; r < 8; r++)
      for (int l = 0; l < 8; l++) begin
        case (pat)
          0: blk_c[r][l] = 0;
          1: blk_c[r][l] = (r == 0 && l == 0) ? wrap($urandom) : 0;
          2: blk_c[r][l] = 32767;
          3: blk_c[r][l] = -32768;
          4: blk_c[r][l] = ((r + l) % 2) ? -32768 : 32767;
          5: blk_c[r][l] = $signed($urandom % 512) - 256;
          6: blk_c[r][l] = wrap($urandom);
          default: blk_c[r][l] = (r == (b % 7) && l == (b % 5)) ? wrap($urandom) : 0;
        endcase
        case (b % 3)
          0: blk_p[r][l] = $urandom % 256;
          1: blk_p[r][l] = 255;
          default: blk_p[r][l] = 0;
        endcase
      end
  endtask

  task automatic drive_row(int r);
    for (int l = 0; l < 8; l++) begin
      coef_row_i[l*16 +: 16] = blk_c[r][l][15:0];
      pred_row_i[l*8 +: 8]   = blk_p[r][l][7:0];
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor
  bit prev_valid = 0;
  logic [2:0] prev_idx = '0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (row_valid_o) begin
        logic [63:0] e;
        bit m;
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R7 unexpected row act=%h exp=none", pix_row_o);
        end else begin
          e = exp_q.pop_front();
          m = mode_q.pop_front();
          if (pix_row_o !== e) begin
            n_fail++;
            if (m) $display("FAIL R1 R2 R3 R4 R6 R9 R11 row %0d act=%h exp=%h", row_idx_o, pix_row_o, e);
            else   $display("FAIL R1 R2 R3 R4 R5 R9 R11 row %0d act=%h exp=%h", row_idx_o, pix_row_o, e);
          end
          // R7 order and latency
          if (row_idx_o !== 3'(7 - exp_q.size() % 8) || cyc != acc_cyc + 17 + int'(row_idx_o)) begin
            n_fail++;
            $display("FAIL R7 idx/cycle act=%0d/%0d exp=%0d/%0d", row_idx_o, cyc,
                     7 - exp_q.size() % 8, acc_cyc + 17 + int'(row_idx_o));
          end
        end
      end
      if (done_o) begin
        n_chk++;
        if (!(prev_valid && prev_idx == 3'd7 && in_ready_o && !row_valid_o)) begin
          n_fail++;
          $display("FAIL R8 done act=prev_valid %0b prev_idx %0d ready %0b exp=1 7 1", prev_valid, prev_idx, in_ready_o);
        end
      end
      prev_valid = row_valid_o;
      prev_idx   = row_idx_o;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (in_ready_o !== 1'b1 || row_valid_o !== 1'b0 || done_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset act=%b%b%b exp=100", in_ready_o, row_valid_o, done_o);
    end
    rst_ni = 1'b1;
    for (int b = 0; b < NBLK; b++) begin
      bit addm;
      gen_block(b, addm);
      model(addm);
      for (int r = 0; r < 8;) begin
        @(negedge clk_i);
        in_valid_i = 1'b1;
        if (in_ready_o) begin
          drive_row(r);
          add_mode_i = (r == 0) ? addm : 1'($urandom);  // R9
          if (r == 7) acc_cyc = cyc + 1;
          r++;
        end else begin
          // R8 junk while busy
          coef_row_i = {4{$urandom}};
          pred_row_i = {2{$urandom}};
          add_mode_i = 1'($urandom);
        end
      end
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    while (exp_q.size() != 0) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=completion");
    finish_run();
  end
endmodule